// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the hardware consumer of a transmit descriptor ring that lives in a shared buffer memory. Software owns the producer index and hardware owns the consumer index. Software sets up the ring with three values: the byte address of the descriptor array, the byte address of a parallel status array, and the index of the last ring slot (the entry count minus one). It then fills one or more buffers, writes their descriptors, and moves the producer index forward. As long as the two indices differ and the engine is enabled, the engine handles one slot at a time. For each slot it reads the buffer address and the control word over a request/acknowledge memory port. It offers the buffer to a frame-output handshake and waits for the sender to report completion. It then records a status word in the matching status slot and steps the consumer index forward, wrapping at the end of the ring.

When the consumer index catches up with the producer index, the engine pulses a one-cycle interrupt. Software can post several slots in one producer update. The engine then works through all of them in ring order and raises the interrupt only once, after the last one.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the consumer index is 0, and no memory request, frame offer or interrupt is active.
- R2: The `last_idx` input holds the number of ring entries minus one. The consumer index counts up from 0 and goes from `last_idx` back to 0.
- R3: For slot i the engine reads the buffer address from byte address `desc_base + 8*i`, then reads the control word from `desc_base + 8*i + 4`. The frame length is control bits [15:0], and the higher control bits are ignored.
- R4: While the producer and consumer indices are equal, the engine makes no memory request and offers no frame.
- R5: A frame offer (`fo_valid` with `fo_addr` and `fo_len`) stays asserted and unchanged until the cycle in which `fo_ready` is high.
- R6: After `fo_done`, the engine writes the status word to byte address `stat_base + 4*i`. Bit 31 holds the `fo_err` value given with `fo_done`, bits [30:16] are zero, and bits [15:0] hold the frame length. The write completes before the consumer index moves.
- R7: A producer update that covers several slots makes the engine send all of them, one after another, in ring order and with no further software action.
- R8: `irq_done` is high for exactly one cycle, in the cycle right after the consumer index becomes equal to the producer index.
- R9: While `en` is low, the engine starts no new slot, so a producer index change has no effect. Once `en` rises, the engine processes the pending slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable for starting new slots |
| desc_base | input | 16 | Byte address of descriptor array |
| stat_base | input | 16 | Byte address of status array |
| last_idx | input | 8 | Ring entries minus one |
| prod_idx | input | 8 | Software producer index |
| cons_idx | output | 8 | Hardware consumer index |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| fo_valid | output | 1 | Frame offer valid |
| fo_addr | output | 16 | Offered buffer address |
| fo_len | output | 16 | Offered frame length in bytes |
| fo_ready | input | 1 | Frame offer accepted |
| fo_done | input | 1 | Frame transmission finished |
| fo_err | input | 1 | Error flag, valid with fo_done |
| irq_done | output | 1 | One-cycle ring-drained pulse |

## Verification
The assertions assume three things about the inputs. First, `last_idx` and the base addresses stay fixed between resets. Second, `fo_done` only arrives after an accepted offer. Third, software never moves the producer more than `last_idx` slots ahead of the consumer. The bench always reconfigures the ring under reset. Its sender model raises `fo_done` only after a handshake, and each random burst size is drawn between one and `last_idx`, posted only after the previous burst has drained. Memory and sender latencies are random, which exercises the hold rules on both handshakes.

// File: rtl/tre_pkg.sv
package tre_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_BUF,
      ST_RD_CTL,
      ST_OFFER,
      ST_WAIT,
      ST_WR_STAT,
      ST_ADV
   } tre_state_e;
endpackage

// File: rtl/tre_ring_idx.sv
module tre_ring_idx #(
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [IW-1:0] last_idx,
   input  logic [IW-1:0] prod_idx,
   output logic [IW-1:0] cons_idx,
   output logic          empty,
   output logic          drained
);
   logic [IW-1:0] step_idx;

   assign step_idx = (cons_idx == last_idx) ? '0 : cons_idx + 1'b1;
   assign empty    = (cons_idx == prod_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cons_idx <= '0;
         drained  <= 1'b0;
      end else begin
         drained <= adv && (step_idx == prod_idx);
         if (adv) cons_idx <= step_idx;
      end
   end

   // R2: the top slot wraps to zero
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cons_idx == last_idx) |=> (cons_idx == '0));
   // R2: the index stays inside the ring
   a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cons_idx <= last_idx));
   // R8: the drained pulse lasts one cycle
   a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      drained |=> !drained);
endmodule

// File: rtl/tre_addr_gen.sv
module tre_addr_gen #(
   parameter int AW         = 16,
   parameter int IW         = 8,
   parameter int WB         = 4,
   parameter int DESC_WORDS = 2
) (
   input  logic [AW-1:0] desc_base,
   input  logic [AW-1:0] stat_base,
   input  logic [IW-1:0] idx,
   input  logic          ctl_word,
   output logic [AW-1:0] desc_addr,
   output logic [AW-1:0] stat_addr
);
   localparam int STRIDE   = DESC_WORDS * WB;
   localparam int WB_SH    = $clog2(WB);
   localparam bit STR_POW2 = ((STRIDE & (STRIDE - 1)) == 0);

   logic [AW-1:0] idx_w;
   logic [AW-1:0] slot_off;
   logic [AW-1:0] word_off;

   assign idx_w    = {{(AW-IW){1'b0}}, idx};
   assign word_off = ctl_word ? AW'(WB) : '0;

   generate
      if (STR_POW2) begin : g_shift
         assign slot_off = idx_w << $clog2(STRIDE);
      end else begin : g_mult
         assign slot_off = idx_w * AW'(STRIDE);
      end
   endgenerate

   assign desc_addr = desc_base + slot_off + word_off;
   assign stat_addr = stat_base + (idx_w << WB_SH);
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
   import tre_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 32,
   parameter int IW         = 8,
   parameter int LW         = 16,
   parameter int DESC_WORDS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [AW-1:0] desc_base,
   input  logic [AW-1:0] stat_base,
   input  logic [IW-1:0] last_idx,
   input  logic [IW-1:0] prod_idx,
   output logic [IW-1:0] cons_idx,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          fo_valid,
   output logic [AW-1:0] fo_addr,
   output logic [LW-1:0] fo_len,
   input  logic          fo_ready,
   input  logic          fo_done,
   input  logic          fo_err,
   output logic          irq_done
);
   localparam int WB  = DW / 8;
   localparam int UW  = (AW > LW) ? AW : LW;
   localparam int PAD = DW - 1 - LW;

   generate
      if (DW % 8 != 0 || (WB & (WB - 1)) != 0) begin : g_bad_dw
         $error("data width must be a power-of-two number of bytes");
      end
      if (AW > DW || AW <= IW) begin : g_bad_aw
         $error("address width must exceed index width and fit in a word");
      end
      if (LW > DW - 2) begin : g_bad_lw
         $error("length field leaves no room for the error flag");
      end
      if (DESC_WORDS < 2) begin : g_bad_dwords
         $error("descriptor needs at least two words");
      end
   endgenerate

   tre_state_e    state, state_nx;
   logic [AW-1:0] buf_q;
   logic [LW-1:0] len_q;
   logic          err_q;
   logic          adv, empty;
   logic [AW-1:0] desc_addr, stat_addr;

   tre_ring_idx #(.IW(IW)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .last_idx (last_idx),
      .prod_idx (prod_idx),
      .cons_idx (cons_idx),
      .empty    (empty),
      .drained  (irq_done)
   );

   tre_addr_gen #(.AW(AW), .IW(IW), .WB(WB), .DESC_WORDS(DESC_WORDS)) u_addr (
      .desc_base (desc_base),
      .stat_base (stat_base),
      .idx       (cons_idx),
      .ctl_word  (state == ST_RD_CTL),
      .desc_addr (desc_addr),
      .stat_addr (stat_addr)
   );

   generate
      if (UW < DW) begin : g_unused_hi
         logic unused_rdata_hi;
         assign unused_rdata_hi = ^mem_rdata[DW-1:UW];
      end
   endgenerate

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:    if (en && !empty) state_nx = ST_RD_BUF;
         ST_RD_BUF:  if (mem_ack)      state_nx = ST_RD_CTL;
         ST_RD_CTL:  if (mem_ack)      state_nx = ST_OFFER;
         ST_OFFER:   if (fo_ready)     state_nx = ST_WAIT;
         ST_WAIT:    if (fo_done)      state_nx = ST_WR_STAT;
         ST_WR_STAT: if (mem_ack)      state_nx = ST_ADV;
         ST_ADV:                       state_nx = ST_IDLE;
         default:                      state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         buf_q <= '0;
         len_q <= '0;
         err_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_RD_BUF && mem_ack) buf_q <= mem_rdata[AW-1:0];
         if (state == ST_RD_CTL && mem_ack) len_q <= mem_rdata[LW-1:0];
         if (state == ST_WAIT && fo_done)   err_q <= fo_err;
      end
   end

   assign adv       = (state == ST_ADV);
   assign mem_req   = (state == ST_RD_BUF) || (state == ST_RD_CTL) || (state == ST_WR_STAT);
   assign mem_we    = (state == ST_WR_STAT);
   assign mem_addr  = mem_we ? stat_addr : desc_addr;
   assign mem_wdata = {err_q, {PAD{1'b0}}, len_q};
   assign fo_valid  = (state == ST_OFFER);
   assign fo_addr   = buf_q;
   assign fo_len    = len_q;

   // R5: an offer is held steady until accepted
   a_r5_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fo_valid && !fo_ready) |=> (fo_valid && $stable(fo_addr) && $stable(fo_len)));
   // R4: a fetch only begins when the ring holds work
   a_r4_start_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_BUF && $past(state) == ST_IDLE) |-> $past(prod_idx != cons_idx));
   // R9: a fetch only begins while enabled
   a_r9_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_BUF && $past(state) == ST_IDLE) |-> $past(en));
   // R6: the status write is acknowledged before the index moves
   a_r6_stat_before_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_idx != $past(cons_idx)) |-> $past(mem_we && mem_ack, 2));
   // R3: memory request held with a steady address until acknowledged
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/tx_ring_engine_test.sv
module tx_ring_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16, DW = 32, IW = 8, LW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [AW-1:0] desc_base = '0, stat_base = '0;
   logic [IW-1:0] last_idx = '0, prod_idx = '0;
   logic [IW-1:0] cons_idx;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          fo_valid;
   logic [AW-1:0] fo_addr;
   logic [LW-1:0] fo_len;
   logic          fo_ready = 1'b0, fo_done = 1'b0, fo_err = 1'b0;
   logic          irq_done;

   tx_ring_engine uut (
      .clk(clk), .rst_n(rst_n), .en(en), .desc_base(desc_base), .stat_base(stat_base),
      .last_idx(last_idx), .prod_idx(prod_idx), .cons_idx(cons_idx),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fo_valid(fo_valid), .fo_addr(fo_addr),
      .fo_len(fo_len), .fo_ready(fo_ready), .fo_done(fo_done), .fo_err(fo_err),
      .irq_done(irq_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [DW-1:0] mem [0:255];
   logic [AW-1:0] sd_addr [0:15];
   logic [LW-1:0] sd_len  [0:15];
   logic          serr    [0:15];
   int            posted [0:15];
   int            posted_n;
   int            n_chk = 0, n_bad = 0;
   int            exp_slot = 0, pend_slot = 0, sw_prod = 0;
   int            done_cnt = 0, irq_cnt = 0, act_cnt = 0;
   logic          irq_prev = 1'b0, offer_prev = 1'b0;
   logic [AW-1:0] offer_addr_prev = '0;
   logic [LW-1:0] offer_len_prev = '0;

   task automatic check(input logic ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int nxt(input int i);
      return (i == int'(last_idx)) ? 0 : i + 1;
   endfunction

   function automatic logic [DW-1:0] stat_word(input logic e, input logic [LW-1:0] l);
      return {e, {(DW-1-LW){1'b0}}, l};
   endfunction

   // memory, sender and interrupt models, all acting on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req && ($urandom % 3 == 0)) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               check(mem_addr == stat_base + AW'(4*pend_slot), "R6 status address", mem_addr, stat_base + AW'(4*pend_slot));
               check(cons_idx == IW'(pend_slot), "R6 index unchanged at status write", cons_idx, pend_slot);
               mem[mem_addr[9:2]] = mem_wdata;
            end else mem_rdata = mem[mem_addr[9:2]];
         end
         if (fo_done) fo_done = 1'b0;
         if (done_cnt > 0) begin
            done_cnt--;
            if (done_cnt == 0) begin
               fo_done = 1'b1;
               fo_err = 1'($urandom);
               serr[pend_slot] = fo_err;
            end
         end
         if (offer_prev && !fo_ready) begin
            check(fo_valid && fo_addr == offer_addr_prev && fo_len == offer_len_prev,
                  "R5 offer held", {fo_valid, fo_addr}, {1'b1, offer_addr_prev});
         end
         offer_prev = fo_valid; offer_addr_prev = fo_addr; offer_len_prev = fo_len;
         if (fo_ready) fo_ready = 1'b0;
         else if (fo_valid && ($urandom % 2 == 0)) begin
            fo_ready = 1'b1;
            check(fo_addr == sd_addr[exp_slot], "R3 buffer address", fo_addr, sd_addr[exp_slot]);
            check(fo_len == sd_len[exp_slot], "R7 length in ring order", fo_len, sd_len[exp_slot]);
            pend_slot = exp_slot;
            exp_slot = nxt(exp_slot);
            done_cnt = 1 + int'($urandom % 6);
         end
         if (irq_done) begin
            irq_cnt++;
            check(cons_idx == prod_idx, "R8 irq when drained", cons_idx, prod_idx);
            check(!irq_prev, "R8 irq single cycle", irq_prev, 0);
         end
         irq_prev = irq_done;
         if (mem_req || fo_valid) act_cnt++;
      end
   end

   task automatic do_reset(input int last, input logic [AW-1:0] db, input logic [AW-1:0] sb);
      @(negedge clk);
      rst_n = 1'b0; en = 1'b0; prod_idx = '0;
      last_idx = IW'(last); desc_base = db; stat_base = sb;
      exp_slot = 0; sw_prod = 0; done_cnt = 0; fo_ready = 1'b0; fo_done = 1'b0; mem_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cons_idx == '0, "R1 reset index", cons_idx, 0);
      check(!mem_req && !fo_valid && !irq_done, "R1 reset outputs idle", {mem_req, fo_valid, irq_done}, 0);
   endtask

   task automatic post(input int k);
      posted_n = 0;
      for (int j = 0; j < k; j++) begin
         sd_addr[sw_prod] = AW'($urandom);
         sd_len[sw_prod]  = LW'(1 + $urandom % 1500);
         mem[(desc_base >> 2) + AW'(2*sw_prod)]     = {{(DW-AW){1'b0}}, sd_addr[sw_prod]};
         mem[(desc_base >> 2) + AW'(2*sw_prod + 1)] = {16'($urandom), sd_len[sw_prod]};
         mem[(stat_base >> 2) + AW'(sw_prod)]       = '1;
         posted[posted_n] = sw_prod;
         posted_n++;
         sw_prod = nxt(sw_prod);
      end
      @(negedge clk);
      prod_idx = IW'(sw_prod);
   endtask

   task automatic drain_and_verify();
      int start;
      bit got;
      start = irq_cnt;
      got = 0;
      for (int c = 0; c < 20000 && !got; c++) begin
         @(negedge clk);
         if (irq_cnt > start) got = 1;
      end
      check(got, "R8 drain interrupt seen", got, 1);
      repeat (3) @(negedge clk);
      check(cons_idx == IW'(sw_prod), "R2 index after drain", cons_idx, sw_prod);
      for (int j = 0; j < posted_n; j++) begin
         int s;
         s = posted[j];
         check(mem[(stat_base >> 2) + AW'(s)] == stat_word(serr[s], sd_len[s]),
               "R6 status word", mem[(stat_base >> 2) + AW'(s)], stat_word(serr[s], sd_len[s]));
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) mem[i] = '0;
      do_reset(5, 16'h0100, 16'h0300);

      // R9: posting while disabled does nothing
      post(3);
      act_cnt = 0;
      repeat (40) @(negedge clk);
      check(act_cnt == 0, "R9 no activity while disabled", act_cnt, 0);
      check(cons_idx == '0, "R9 index held while disabled", cons_idx, 0);
      en = 1'b1;
      drain_and_verify();

      // R2: burst of four crossing the top slot (3,4,5,0)
      post(4);
      drain_and_verify();
      check(cons_idx == IW'(1), "R2 wrapped index", cons_idx, 1);

      // R4: empty ring stays quiet
      act_cnt = 0;
      repeat (30) @(negedge clk);
      check(act_cnt == 0, "R4 idle when empty", act_cnt, 0);

      // R7: random bursts up to the full limit
      for (int r = 0; r < 20; r++) begin
         post(1 + int'($urandom % 5));
         drain_and_verify();
      end

      // second ring geometry: three entries, different bases
      do_reset(2, 16'h0040, 16'h00C0);
      en = 1'b1;
      post(2);
      drain_and_verify();
      for (int r = 0; r < 12; r++) begin
         post(1 + int'($urandom % 2));
         drain_and_verify();
      end
      act_cnt = 0;
      repeat (20) @(negedge clk);
      check(act_cnt == 0, "R4 idle after final drain", act_cnt, 0);
      finish_run();
   end
endmodule